// File: doc/BRIEF.md
# Compare-Match Port Reset/Toggle Unit

This block owns an 8-bit output port. Two timer compare channels can change the port without software. The comparators sit outside the block, and each one signals an event as a single-clock pulse. A software-writable enable register chooses which pins respond to these pulses. The enable register splits the port into two groups. The two upper pins invert when the second compare channel fires. The six lower pins are driven low when the first compare channel fires. A pin whose enable bit is clear ignores both channels.

Software can also load the port directly through a write path. If that write lands in the same cycle as a match pulse, the match acts on the value being written. The enable register reads back on its own output. The number of pins and the size of the toggle group are parameters.

Top module: `cmp_port_unit`

## Requirements
- R1: While reset is asserted, the port output is all ones (8'hFF) and the enable readback is all zeros.
- R2: A cycle with `en_wr` high loads `en_wdata` into the enable register, and `en_rd` shows it from the next cycle.
- R3: A `match_tgl` pulse inverts each of port bits 7 and 6 whose enable bit is set. The change is visible in the next cycle.
- R4: A `match_clr` pulse drives low each of port bits 5 down to 0 whose enable bit is set. The change is visible in the next cycle.
- R5: A port bit whose enable bit is clear keeps its value when either match pulse arrives, as long as no port write occurs.
- R6: `match_tgl` never changes bits 5 to 0, and `match_clr` never changes bits 7 and 6, whatever the enable bits are.
- R7: Each cycle in which `match_tgl` is high produces exactly one inversion. Two pulses in a row on an enabled upper pin restore its original value.
- R8: A cycle with `port_wr` high and no match pulse loads `port_wdata` onto the port for the next cycle.
- R9: When `port_wr` and a match pulse occur in the same cycle, the match action is applied to `port_wdata` rather than to the old port value.
- R10: When an enable write and a match pulse occur in the same cycle, the match uses the enable value held before that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| en_wr | input | 1 | Write strobe for the enable register |
| en_wdata | input | 8 | New enable value |
| port_wr | input | 1 | Direct port write strobe |
| port_wdata | input | 8 | Direct port write value |
| match_clr | input | 1 | First compare channel pulse (clears enabled lower pins) |
| match_tgl | input | 1 | Second compare channel pulse (toggles enabled upper pins) |
| port_out | output | 8 | Port pin values |
| en_rd | output | 8 | Enable register readback |

## Verification
The bench drives each channel with enable patterns that match only the opposite group. A design that ignored group boundaries would clear an upper pin or toggle a lower one. It sends back-to-back toggle pulses, which expose a design that double-counts a pulse or treats the channel as a level. It places a port write in the same cycle as each kind of match, where a design that let the write win would drop the match. It places an enable write in the same cycle as a match, which catches a design that routes the new enable value straight into the match logic.

// File: rtl/cmp_port_unit.sv
module cmp_port_unit #(
  parameter int WIDTH    = 8,
  parameter int TGL_PINS = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en_wr,
  input  logic [WIDTH-1:0] en_wdata,
  input  logic             port_wr,
  input  logic [WIDTH-1:0] port_wdata,
  input  logic             match_clr,
  input  logic             match_tgl,
  output logic [WIDTH-1:0] port_out,
  output logic [WIDTH-1:0] en_rd
);
  localparam logic [WIDTH-1:0] TGL_MASK = {WIDTH{1'b1}} << (WIDTH - TGL_PINS);
  localparam logic [WIDTH-1:0] CLR_MASK = ~TGL_MASK;

  logic [WIDTH-1:0] en_q, port_q, base, clr_hit, tgl_hit;

  assign base    = port_wr ? port_wdata : port_q;
  assign clr_hit = {WIDTH{match_clr}} & en_q & CLR_MASK;
  assign tgl_hit = {WIDTH{match_tgl}} & en_q & TGL_MASK;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= '0;
      port_q <= '1;
    end else begin
      if (en_wr) en_q <= en_wdata;
      port_q <= (base & ~clr_hit) ^ tgl_hit;
    end
  end

  assign port_out = port_q;
  assign en_rd    = en_q;
endmodule

module cmp_port_unit_chk #(
  parameter int WIDTH    = 8,
  parameter int TGL_PINS = 2
) (
  input logic             clk,
  input logic             rst_n,
  input logic             en_wr,
  input logic [WIDTH-1:0] en_wdata,
  input logic             port_wr,
  input logic [WIDTH-1:0] port_wdata,
  input logic             match_clr,
  input logic             match_tgl,
  input logic [WIDTH-1:0] port_out,
  input logic [WIDTH-1:0] en_rd
);
  always @(negedge clk)
    if (!rst_n) p_reset_r1: assert (port_out == '1 && en_rd == '0);

  p_enwr_r2: assert property (@(posedge clk) disable iff (!rst_n)
    en_wr |=> en_rd == $past(en_wdata));

  p_load_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (port_wr && !match_clr && !match_tgl) |=> port_out == $past(port_wdata));

  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    // R5, R10: the enable seen in the match cycle governs
    p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (!port_wr && !en_rd[i]) |=> $stable(port_out[i]));
    if (i >= WIDTH - TGL_PINS) begin : g_up
      // R3, R7
      p_toggle_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (match_tgl && !port_wr && en_rd[i]) |=> port_out[i] != $past(port_out[i]));
      p_cross_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!port_wr && !match_tgl) |=> $stable(port_out[i]));
      p_wrtgl_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (port_wr && match_tgl && en_rd[i]) |=> port_out[i] != $past(port_wdata[i]));
    end else begin : g_lo
      p_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (match_clr && en_rd[i]) |=> !port_out[i]);
      p_cross_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!port_wr && !match_clr) |=> $stable(port_out[i]));
    end
  end
endmodule

bind cmp_port_unit cmp_port_unit_chk #(.WIDTH(WIDTH), .TGL_PINS(TGL_PINS)) u_chk (.*);

// File: tb/sim_cmp_port_unit.sv
module sim_cmp_port_unit;
  logic clk = 0, rst_n = 0;
  logic en_wr = 0, port_wr = 0, match_clr = 0, match_tgl = 0;
  logic [7:0] en_wdata = 0, port_wdata = 0, port_out, en_rd;
  int checks = 0, errors = 0;

  typedef struct { logic [7:0] port; logic [7:0] en; string tag; } item_t;
  item_t q[$];
  logic [7:0] m_port = 8'hFF, m_en = 8'h00;

  always #4 clk = ~clk;

  cmp_port_unit u0 (.*);

  task automatic step(string tag, bit ew, logic [7:0] ed, bit pw, logic [7:0] pd, bit mc, bit mt);
    logic [7:0] nx;
    item_t it;
    @(negedge clk);
    en_wr = ew; en_wdata = ed; port_wr = pw; port_wdata = pd;
    match_clr = mc; match_tgl = mt;
    nx = pw ? pd : m_port;
    if (mc) nx = nx & ~(m_en & 8'h3F);
    if (mt) nx = nx ^ (m_en & 8'hC0);
    m_port = nx;
    if (ew) m_en = ed;
    it.port = m_port; it.en = m_en; it.tag = tag;
    q.push_back(it);
  endtask

  always @(posedge clk) begin
    if (rst_n) begin
      #2;
      if (q.size() > 0) begin
        item_t e;
        e = q.pop_front();
        checks++;
        if (port_out !== e.port || en_rd !== e.en) begin
          errors++;
          $display("FAIL %s: port=%h en=%h expected port=%h en=%h", e.tag, port_out, en_rd, e.port, e.en);
        end
      end
    end
  end

  initial begin
    #100000;
    errors++;
    $display("FAIL watchdog: run did not complete, expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    checks++;
    if (port_out !== 8'hFF || en_rd !== 8'h00) begin
      errors++;
      $display("FAIL R1: port=%h en=%h expected port=ff en=00", port_out, en_rd);
    end
    rst_n = 1;
    step("R5", 0, 0, 0, 0, 1, 0);
    step("R5", 0, 0, 0, 0, 0, 1);
    step("R8", 0, 0, 1, 8'hA5, 0, 0);
    step("R2", 1, 8'hFF, 0, 0, 0, 0);
    step("R4", 0, 0, 0, 0, 1, 0);
    step("R3", 0, 0, 0, 0, 0, 1);
    step("R7", 0, 0, 0, 0, 0, 1);
    step("R7", 0, 0, 0, 0, 0, 1);
    step("R8", 0, 0, 1, 8'h3C, 0, 0);
    step("R2", 1, 8'hC0, 0, 0, 0, 0);
    step("R6", 0, 0, 0, 0, 1, 0);
    step("R2", 1, 8'h3F, 0, 0, 0, 0);
    step("R8", 0, 0, 1, 8'hFF, 0, 0);
    step("R6", 0, 0, 0, 0, 0, 1);
    step("R2", 1, 8'h85, 0, 0, 0, 0);
    step("R5", 0, 0, 0, 0, 1, 1);
    step("R5", 0, 0, 0, 0, 0, 1);
    step("R9", 0, 0, 1, 8'h7F, 1, 0);
    step("R9", 0, 0, 1, 8'h0F, 0, 1);
    step("R9", 0, 0, 1, 8'hFF, 1, 1);
    step("R10", 1, 8'hFF, 0, 0, 1, 1);
    step("R10", 1, 8'h00, 0, 0, 1, 1);
    step("R10", 0, 0, 0, 0, 1, 1);
    step("R8", 0, 0, 0, 0, 0, 0);
    repeat (3) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule